// File: doc/BRIEF.md
# Paged Program Window Translator

This block sits between a processor's 16-bit address bus and a wider physical memory space. One fixed 16 KB slice of the processor's address map acts as a program window. Any access that lands in the window is steered to one of 256 physical 16 KB pages. An 8-bit page register picks the page. This reaches a 4 MB physical space, and the processor's own addressing stays unchanged. Every access outside the window maps one to one into the bottom of the physical space.

Software changes pages by writing the page register through a single write strobe, and can read the register back at any time. The new page takes effect on exactly one clock edge. An access in the same cycle as the write still uses the old page. This lets code switch banks without masking interrupts. Translation is combinational from the registered page by default. A parameter selects a variant that registers the output, adding one cycle of latency.

Top module: `pwt_translator`

## Requirements
- R1: After reset the page register holds 0x00, and `pg_rdata` shows 0x00.
- R2: When `pg_wr` is 1 at a rising clock edge, the page register takes `pg_wdata`. The new value shows on `pg_rdata` from that edge on.
- R3: With `acc_vld` = 1 and `cpu_addr` in 0x8000..0xBFFF (that is, `cpu_addr[15:14]` = 2'b10), `in_win` is 1 and `phys_addr` = {page[7:0], cpu_addr[13:0]}.
- R4: With `acc_vld` = 1 and `cpu_addr` outside 0x8000..0xBFFF, `in_win` is 0 and `phys_addr` = {6'b0, cpu_addr}.
- R5: With `acc_vld` = 0, `in_win` is 0 and `phys_addr` is 0, whatever the value of `cpu_addr`.
- R6: A translation in the same cycle as a page write uses the old page. The written page applies from the next cycle.
- R7: The window edges are exact. Addresses 0x7FFF and 0xC000 are outside the window. Addresses 0x8000 and 0xBFFF are inside it.
- R8: Page 0xFF with window offset 0x3FFF gives `phys_addr` 0x3FFFFF. Page 0x00 with offset 0 gives 0x000000.
- R9: While `pg_wr` is 0, the page register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Processor address |
| acc_vld | input | 1 | Access is valid this cycle |
| pg_wr | input | 1 | Page register write strobe |
| pg_wdata | input | 8 | Page register write data |
| pg_rdata | output | 8 | Page register read-back |
| phys_addr | output | 22 | Translated physical address |
| in_win | output | 1 | Access falls in the program window |

## Verification
The assertions assume that `cpu_addr`, `acc_vld`, `pg_wr` and `pg_wdata` are stable and known around each rising edge. They also assume that reset is held for at least one edge before any access. The bench drives every input on the falling edge, so it changes nothing close to a sampling edge. It holds reset for several cycles before the first access. Random addresses are biased toward the window edges and the top of the range, so the decode edges are covered as often as the interior.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
   typedef enum logic [0:0] {
      OUT_COMB = 1'b0,
      OUT_REG  = 1'b1
   } out_mode_e;
endpackage

// File: rtl/pwt_page_reg.sv
module pwt_page_reg #(
   parameter int PAGE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [PAGE_W-1:0] wdata,
   output logic [PAGE_W-1:0] page
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  page <= '0;
      else if (wr) page <= wdata;
   end
endmodule

// File: rtl/pwt_win_decode.sv
module pwt_win_decode #(
   parameter int CPU_AW  = 16,
   parameter int OFS_W   = 14,
   parameter int WIN_IDX = 2
) (
   input  logic [CPU_AW-1:0] addr,
   input  logic              vld,
   output logic              hit
);
   localparam int SEL_W = CPU_AW - OFS_W;
   localparam logic [SEL_W-1:0] SEL_VAL = SEL_W'(WIN_IDX);

   always_comb hit = vld && (addr[CPU_AW-1:OFS_W] == SEL_VAL);
endmodule

// File: rtl/pwt_addr_mux.sv
module pwt_addr_mux #(
   parameter int CPU_AW  = 16,
   parameter int OFS_W   = 14,
   parameter int PAGE_W  = 8,
   parameter int PHYS_AW = PAGE_W + OFS_W
) (
   input  logic [CPU_AW-1:0]  addr,
   input  logic               vld,
   input  logic               hit,
   input  logic [PAGE_W-1:0]  page,
   output logic [PHYS_AW-1:0] phys
);
   always_comb begin
      if (!vld)     phys = '0;
      else if (hit) phys = {page, addr[OFS_W-1:0]};
      else          phys = PHYS_AW'(addr);
   end
endmodule

// File: rtl/pwt_translator.sv
module pwt_translator
   import pwt_pkg::*;
#(
   parameter int        CPU_AW   = 16,
   parameter int        OFS_W    = 14,
   parameter int        PAGE_W   = 8,
   parameter int        WIN_IDX  = 2,
   parameter out_mode_e OUT_MODE = OUT_COMB,
   localparam int       PHYS_AW  = PAGE_W + OFS_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CPU_AW-1:0]  cpu_addr,
   input  logic               acc_vld,
   input  logic               pg_wr,
   input  logic [PAGE_W-1:0]  pg_wdata,
   output logic [PAGE_W-1:0]  pg_rdata,
   output logic [PHYS_AW-1:0] phys_addr,
   output logic               in_win
);
   localparam int SEL_W = CPU_AW - OFS_W;

   if (OFS_W < 1 || OFS_W >= CPU_AW) begin : g_bad_ofs
      $error("pwt_translator: OFS_W must lie in 1..CPU_AW-1");
   end
   if (WIN_IDX < 0 || WIN_IDX >= (1 << SEL_W)) begin : g_bad_idx
      $error("pwt_translator: WIN_IDX does not fit the select field");
   end
   if (PHYS_AW < CPU_AW) begin : g_bad_phys
      $error("pwt_translator: physical space narrower than cpu space");
   end
   if (PAGE_W < 1) begin : g_bad_page
      $error("pwt_translator: PAGE_W must be positive");
   end

   logic [PAGE_W-1:0]  page_q;
   logic               hit_c;
   logic [PHYS_AW-1:0] phys_c;

   pwt_page_reg #(.PAGE_W(PAGE_W)) u_page (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (pg_wr),
      .wdata (pg_wdata),
      .page  (page_q)
   );

   pwt_win_decode #(.CPU_AW(CPU_AW), .OFS_W(OFS_W), .WIN_IDX(WIN_IDX)) u_dec (
      .addr (cpu_addr),
      .vld  (acc_vld),
      .hit  (hit_c)
   );

   pwt_addr_mux #(.CPU_AW(CPU_AW), .OFS_W(OFS_W), .PAGE_W(PAGE_W),
                  .PHYS_AW(PHYS_AW)) u_mux (
      .addr (cpu_addr),
      .vld  (acc_vld),
      .hit  (hit_c),
      .page (page_q),
      .phys (phys_c)
   );

   assign pg_rdata = page_q;

   if (OUT_MODE == OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            phys_addr <= '0;
            in_win    <= 1'b0;
         end else begin
            phys_addr <= phys_c;
            in_win    <= hit_c;
         end
      end
   end else begin : g_out_comb
      always_comb begin
         phys_addr = phys_c;
         in_win    = hit_c;
      end
   end
endmodule

// File: rtl/pwt_translator_chk.sv
module pwt_translator_chk
   import pwt_pkg::*;
#(
   parameter int        CPU_AW   = 16,
   parameter int        OFS_W    = 14,
   parameter int        PAGE_W   = 8,
   parameter int        WIN_IDX  = 2,
   parameter out_mode_e OUT_MODE = OUT_COMB,
   localparam int       PHYS_AW  = PAGE_W + OFS_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic [CPU_AW-1:0]  cpu_addr,
   input logic               acc_vld,
   input logic               pg_wr,
   input logic [PAGE_W-1:0]  pg_wdata,
   input logic [PAGE_W-1:0]  pg_rdata,
   input logic [PHYS_AW-1:0] phys_addr,
   input logic               in_win
);
   localparam int SEL_W = CPU_AW - OFS_W;
   localparam logic [SEL_W-1:0] SEL_VAL = SEL_W'(WIN_IDX);

   logic first_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) first_q <= 1'b1;
      else        first_q <= 1'b0;
   end

   wire in_rng = cpu_addr[CPU_AW-1:OFS_W] == SEL_VAL;

   p_reset_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
      first_q |-> pg_rdata == '0);

   p_page_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pg_wr |=> pg_rdata == $past(pg_wdata));

   p_page_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !pg_wr |=> $stable(pg_rdata));

   if (OUT_MODE == OUT_COMB) begin : g_comb
      p_window_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_vld && in_rng) |-> (in_win && phys_addr == {pg_rdata, cpu_addr[OFS_W-1:0]}));

      p_pass_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_vld && !in_rng) |-> (!in_win && phys_addr == PHYS_AW'(cpu_addr)));

      p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
         !acc_vld |-> (!in_win && phys_addr == '0));
   end else begin : g_reg
      p_window_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!first_q && acc_vld && in_rng) |=>
            (in_win && phys_addr == {$past(pg_rdata), $past(cpu_addr[OFS_W-1:0])}));

      p_pass_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (!first_q && acc_vld && !in_rng) |=>
            (!in_win && phys_addr == PHYS_AW'($past(cpu_addr))));

      p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (!first_q && !acc_vld) |=> (!in_win && phys_addr == '0));
   end
endmodule

bind pwt_translator pwt_translator_chk #(
   .CPU_AW(CPU_AW), .OFS_W(OFS_W), .PAGE_W(PAGE_W),
   .WIN_IDX(WIN_IDX), .OUT_MODE(OUT_MODE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_addr  (cpu_addr),
   .acc_vld   (acc_vld),
   .pg_wr     (pg_wr),
   .pg_wdata  (pg_wdata),
   .pg_rdata  (pg_rdata),
   .phys_addr (phys_addr),
   .in_win    (in_win)
);

// File: tb/sim_pwt_translator.sv
`timescale 1ns/1ps
module sim_pwt_translator;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        acc_vld = 1'b0;
   logic        pg_wr = 1'b0;
   logic [7:0]  pg_wdata = '0;
   logic [7:0]  pg_rdata;
   logic [21:0] phys_addr;
   logic        in_win;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] m_page = 8'h00;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pwt_translator u0 (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .acc_vld(acc_vld),
      .pg_wr(pg_wr), .pg_wdata(pg_wdata), .pg_rdata(pg_rdata),
      .phys_addr(phys_addr), .in_win(in_win)
   );

   function automatic logic exp_win(logic [15:0] a, logic v);
      return v && (a >= 16'h8000) && (a <= 16'hBFFF);
   endfunction

   function automatic logic [21:0] exp_phys(logic [15:0] a, logic v, logic [7:0] pg);
      if (!v) return 22'h0;
      if (exp_win(a, v)) return {pg, a[13:0]};
      return {6'h00, a};
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(logic [15:0] a, logic v, logic w, logic [7:0] wd, string tag);
      @(negedge clk);
      cpu_addr = a; acc_vld = v; pg_wr = w; pg_wdata = wd;
      #1;
      chk({tag, " in_win"}, 32'(in_win), 32'(exp_win(a, v)));
      chk({tag, " phys"}, 32'(phys_addr), 32'(exp_phys(a, v, m_page)));
      chk({tag, " page R9"}, 32'(pg_rdata), 32'(m_page));
      @(posedge clk);
      if (w) m_page = wd;
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (4) @(posedge clk);
      #1 chk("R1 page during reset", 32'(pg_rdata), 32'h0);
      @(negedge clk) rst_n = 1'b1;
      #1 chk("R1 page after reset", 32'(pg_rdata), 32'h0);

      step(16'h8000, 1'b1, 1'b0, 8'h00, "R8 page0 ofs0");
      chk("R8 zero corner", 32'(phys_addr), 32'h0);
      step(16'h7FFF, 1'b1, 1'b0, 8'h00, "R7 below R4");
      step(16'hC000, 1'b1, 1'b0, 8'h00, "R7 above R4");
      step(16'h8000, 1'b1, 1'b1, 8'hFF, "R6 write same cycle R3");
      chk("R6 old page used", 32'(phys_addr), 32'h0);
      step(16'hBFFF, 1'b1, 1'b0, 8'h00, "R8 top R2 R7");
      chk("R8 top corner", 32'(phys_addr), 32'h3FFFFF);
      chk("R2 readback", 32'(pg_rdata), 32'hFF);
      step(16'hBFFF, 1'b0, 1'b0, 8'h00, "R5 idle in range");
      step(16'hFFFF, 1'b1, 1'b0, 8'h00, "R4 top of map");
      step(16'h0000, 1'b1, 1'b1, 8'h5A, "R4 bottom R2");
      step(16'hA123, 1'b1, 1'b0, 8'h00, "R3 page 5A");
      chk("R3 value", 32'(phys_addr), 32'({8'h5A, 14'h2123}));
      step(16'h1234, 1'b0, 1'b1, 8'h3C, "R5 idle with write");
      step(16'h9000, 1'b1, 1'b0, 8'h00, "R9 hold R3");

      for (int i = 0; i < 400; i++) begin
         logic [15:0] a;
         logic v, w;
         logic [7:0] wd;
         case ($urandom % 4)
            0: a = 16'h8000 + 16'($urandom % 3) - 16'd1;
            1: a = 16'hBFFF + 16'($urandom % 3) - 16'd1;
            default: a = 16'($urandom);
         endcase
         v  = ($urandom % 8) != 0;
         w  = ($urandom % 4) == 0;
         wd = 8'($urandom);
         step(a, v, w, wd, "R3 R4 R5 R6 random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule